// File: doc/BRIEF.md
# Bit Mask Logic Unit

This block applies one 16-bit bit-manipulation or logic operation per accepted strobe. The caller presents an opcode, an operand word and a mask word (which doubles as the second operand for the logic operations), and raises `in_valid`. One clock later the block returns the result word, a one-cycle `out_valid` pulse, a write-back qualifier and the test flag T.

The mask-modify operations force or invert only the operand bits selected by the mask. The two test operations compare the selected bits against all ones or all zeros and record the outcome in T. The logic operations combine the two words bitwise, or invert the operand. Each opcode carries its own write-back rule, so the surrounding pipeline can decide from `out_wr_en` alone whether to store the result. Only the test operations change T. Every other opcode leaves T at its last value, so a later conditional branch can still read the result of a test.

Top module: `bmlu_top`

## Requirements
- R1: Opcode 0 (mask set) returns operand | mask: bits selected by a mask 1 become 1, and all other bits keep their operand value.
- R2: Opcode 1 (mask clear) returns operand & ~mask: bits selected by a mask 1 become 0, and all other bits keep their operand value.
- R3: Opcode 2 (mask change) returns operand ^ mask: bits selected by a mask 1 are inverted, and all other bits keep their operand value.
- R4: Opcode 3 (test all set) sets T to 1 exactly when (operand & mask) == mask, and to 0 otherwise. The result equals the operand.
- R5: Opcode 4 (test all clear) sets T to 1 exactly when (operand & mask) == 0, and to 0 otherwise. The result equals the operand.
- R6: Opcodes 5, 6 and 7 return operand AND, OR and XOR mask. Opcode 8 returns ~operand and ignores the mask.
- R7: `out_wr_en` is 1 for opcodes 0, 1, 2, 5, 6, 7 and 8. It is 0 for opcodes 3 and 4, for the unassigned codes 9 to 15, and in any cycle without a result.
- R8: T changes only on an accepted opcode 3 or 4. Every other opcode, and every idle cycle, leaves T at its previous value.
- R9: The result, the write-back qualifier and T appear on the clock edge after the strobe, together with a one-cycle `out_valid`. `out_result` holds its value while no strobe arrives.
- R10: With an all-zero mask, opcodes 3 and 4 both give T = 1, and opcodes 0, 1 and 2 return the operand unchanged.
- R11: Unassigned opcodes 9 to 15 return the operand, with `out_valid` 1, `out_wr_en` 0 and T unchanged.
- R12: While `rst_n` is low, `out_valid`, `out_result`, `out_wr_en` and `out_t` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: this cycle's opcode and words are taken |
| in_op | input | 4 | Operation code |
| in_opnd | input | 16 | Operand word |
| in_mask | input | 16 | Mask word, or second operand for the logic operations |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | 16 | Result word |
| out_wr_en | output | 1 | The result must be written back |
| out_t | output | 1 | Test flag |

## Verification
The bench targets the empty mask and the full mask. A design that tested with `(operand & mask) != 0` would report T = 0 for an empty mask in test-all-set mode. A design that used the wrong logic op for clear would damage bits outside the mask. Long runs of non-test opcodes between tests expose a design that updates or clears T on every strobe: T would then drift away from the last test result. The bench also drives unassigned codes and the NOT opcode with changing masks, which catches write-back asserted on a test or an unknown code, and NOT results that depend on the mask.

// File: rtl/bmlu_pkg.sv
package bmlu_pkg;

    typedef enum logic [3:0] {
        OP_MSET = 4'd0,
        OP_MCLR = 4'd1,
        OP_MCHG = 4'd2,
        OP_TALL = 4'd3,
        OP_TNONE = 4'd4,
        OP_LAND = 4'd5,
        OP_LOR  = 4'd6,
        OP_LXOR = 4'd7,
        OP_LNOT = 4'd8
    } bm_op_e;

    // selector for the mask-modify datapath
    typedef enum logic [1:0] {
        MK_SET = 2'd0,
        MK_CLR = 2'd1,
        MK_CHG = 2'd2,
        MK_NOP = 2'd3
    } mk_kind_e;

    // selector for the logic datapath
    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOT = 2'd3
    } lg_kind_e;

    typedef enum logic [1:0] {
        CL_MOD  = 2'd0,
        CL_LOG  = 2'd1,
        CL_TEST = 2'd2,
        CL_NONE = 2'd3
    } op_class_e;

    function automatic op_class_e op_class(input logic [3:0] op);
        case (op)
            OP_MSET, OP_MCLR, OP_MCHG:           return CL_MOD;
            OP_LAND, OP_LOR, OP_LXOR, OP_LNOT:   return CL_LOG;
            OP_TALL, OP_TNONE:                   return CL_TEST;
            default:                             return CL_NONE;
        endcase
    endfunction

    function automatic mk_kind_e mk_kind(input logic [3:0] op);
        case (op)
            OP_MSET: return MK_SET;
            OP_MCLR: return MK_CLR;
            OP_MCHG: return MK_CHG;
            default: return MK_NOP;
        endcase
    endfunction

    function automatic lg_kind_e lg_kind(input logic [3:0] op);
        case (op)
            OP_LAND: return LG_AND;
            OP_LOR:  return LG_OR;
            OP_LXOR: return LG_XOR;
            default: return LG_NOT;
        endcase
    endfunction

endpackage

// File: rtl/bmlu_maskmod.sv
module bmlu_maskmod
    import bmlu_pkg::*;
#(
    parameter int W = 16
) (
    input  mk_kind_e         kind,
    input  logic [W-1:0]     opnd,
    input  logic [W-1:0]     mask,
    output logic [W-1:0]     res
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (kind)
                MK_SET:  res[i] = opnd[i] | mask[i];
                MK_CLR:  res[i] = opnd[i] & ~mask[i];
                MK_CHG:  res[i] = opnd[i] ^ mask[i];
                default: res[i] = opnd[i];
            endcase
        end
    end

endmodule

// File: rtl/bmlu_logic.sv
module bmlu_logic
    import bmlu_pkg::*;
#(
    parameter int W = 16
) (
    input  lg_kind_e         kind,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     y
);

    always_comb begin
        case (kind)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = ~a;
        endcase
    end

endmodule

// File: rtl/bmlu_test.sv
module bmlu_test #(
    parameter int W = 16
) (
    input  logic [W-1:0] opnd,
    input  logic [W-1:0] mask,
    output logic         all_set,
    output logic         all_clr
);

    // A position passes the set test when it is unselected or holds a one.
    logic [W-1:0] pass_set;
    logic [W-1:0] pass_clr;

    for (genvar i = 0; i < W; i++) begin : g_pos
        assign pass_set[i] = ~mask[i] | opnd[i];
        assign pass_clr[i] = ~mask[i] | ~opnd[i];
    end

    assign all_set = &pass_set;
    assign all_clr = &pass_clr;

endmodule

// File: rtl/bmlu_top.sv
module bmlu_top
    import bmlu_pkg::*;
#(
    parameter int W    = 16,
    parameter int OP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] in_op,
    input  logic [W-1:0]    in_opnd,
    input  logic [W-1:0]    in_mask,
    output logic            out_valid,
    output logic [W-1:0]    out_result,
    output logic            out_wr_en,
    output logic            out_t
);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] res;
        logic         wr;
        logic         t;
    } st_t;

    st_t st_d, st_q;

    logic [3:0]   op4;
    logic [W-1:0] mod_res;
    logic [W-1:0] log_res;
    logic         t_set;
    logic         t_clr;

    assign op4 = 4'(in_op);

    bmlu_maskmod #(.W(W)) u_mod (
        .kind (mk_kind(op4)),
        .opnd (in_opnd),
        .mask (in_mask),
        .res  (mod_res)
    );

    bmlu_logic #(.W(W)) u_log (
        .kind (lg_kind(op4)),
        .a    (in_opnd),
        .b    (in_mask),
        .y    (log_res)
    );

    bmlu_test #(.W(W)) u_tst (
        .opnd    (in_opnd),
        .mask    (in_mask),
        .all_set (t_set),
        .all_clr (t_clr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.wr    = 1'b0;
        if (in_valid) begin
            case (op_class(op4))
                CL_MOD: begin
                    st_d.res = mod_res;
                    st_d.wr  = 1'b1;
                end
                CL_LOG: begin
                    st_d.res = log_res;
                    st_d.wr  = 1'b1;
                end
                CL_TEST: begin
                    st_d.res = in_opnd;
                    st_d.t   = (op4 == OP_TALL) ? t_set : t_clr;
                end
                default: begin
                    st_d.res = in_opnd;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.res;
    assign out_wr_en  = st_q.wr;
    assign out_t      = st_q.t;

endmodule

// File: rtl/bmlu_chk.sv
module bmlu_chk #(
    parameter int W    = 16,
    parameter int OP_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [OP_W-1:0] in_op,
    input logic [W-1:0]    in_opnd,
    input logic [W-1:0]    in_mask,
    input logic            out_valid,
    input logic [W-1:0]    out_result,
    input logic            out_wr_en,
    input logic            out_t
);

    logic is_test;
    assign is_test = (in_op == OP_W'(3)) || (in_op == OP_W'(4));

    // R9: result pulse follows the strobe by one edge
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_result));

    // R7: write-back never without a result, never after a test
    p_wr_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> out_valid);
    p_test_no_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_test) |=> !out_wr_en);

    // R8: T only moves on a test
    p_t_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && is_test) |=> $stable(out_t));

    // R4: test all set
    p_tall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_W'(3)) |=>
            (out_t == (($past(in_opnd) & $past(in_mask)) == $past(in_mask))));

    // R6: NOT ignores the mask
    p_not_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_W'(8)) |=> (out_result == ~$past(in_opnd)));

endmodule

bind bmlu_top bmlu_chk #(.W(W), .OP_W(OP_W)) u_chk (.*);

// File: tb/bmlu_top_test.sv
module bmlu_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  in_op;
    logic [15:0] in_opnd;
    logic [15:0] in_mask;
    logic        out_valid;
    logic [15:0] out_result;
    logic        out_wr_en;
    logic        out_t;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // model state: what the outputs must show at the next sample point
    logic        e_valid = 1'b0;
    logic [15:0] e_res   = '0;
    logic        e_wr    = 1'b0;
    logic        e_t     = 1'b0;
    string       e_tag   = "R12";

    always #2 clk = ~clk;

    bmlu_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_opnd(in_opnd), .in_mask(in_mask), .out_valid(out_valid),
        .out_result(out_result), .out_wr_en(out_wr_en), .out_t(out_t)
    );

    function automatic string tag_of(input logic [3:0] op, input logic [15:0] m);
        if (m == 16'h0 && op <= 4) return "R10";
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5, 6, 7, 8: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // compare the outputs, then present new inputs and advance the model
    task automatic step(input logic v, input logic [3:0] op,
                        input logic [15:0] a, input logic [15:0] m);
        @(negedge clk);
        chk("R9", "valid", int'(out_valid), int'(e_valid));
        chk(e_tag, "result", int'(out_result), int'(e_res));
        chk("R7", "wr_en", int'(out_wr_en), int'(e_wr));
        chk("R8", "t", int'(out_t), int'(e_t));
        in_valid = v; in_op = op; in_opnd = a; in_mask = m;
        e_valid = v;
        e_wr    = 1'b0;
        if (v) begin
            e_tag = tag_of(op, m);
            case (op)
                0: begin e_res = a | m;  e_wr = 1'b1; end
                1: begin e_res = a & ~m; e_wr = 1'b1; end
                2: begin e_res = a ^ m;  e_wr = 1'b1; end
                3: begin e_res = a; e_t = ((a & m) == m); end
                4: begin e_res = a; e_t = ((a & m) == 16'h0); end
                5: begin e_res = a & m;  e_wr = 1'b1; end
                6: begin e_res = a | m;  e_wr = 1'b1; end
                7: begin e_res = a ^ m;  e_wr = 1'b1; end
                8: begin e_res = ~a;     e_wr = 1'b1; end
                default: e_res = a;
            endcase
        end else begin
            e_tag = "R9";
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_opnd = '0; in_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk("R12", "valid", int'(out_valid), 0);
        chk("R12", "result", int'(out_result), 0);
        chk("R12", "wr_en", int'(out_wr_en), 0);
        chk("R12", "t", int'(out_t), 0);
        rst_n = 1'b1;
        e_tag = "R12";
        // directed patterns
        step(1, 0, 16'h1200, 16'h00F0);       // R1
        step(1, 1, 16'hFFFF, 16'h0F0F);       // R2
        step(1, 2, 16'hAAAA, 16'hFF00);       // R3
        step(1, 3, 16'hF0F3, 16'h0033);       // R4 true
        step(1, 5, 16'h1234, 16'h00FF);       // R8 hold across logic op
        step(1, 3, 16'hF0F0, 16'h0033);       // R4 false
        step(1, 4, 16'hF0F0, 16'h0303);       // R5 true
        step(1, 4, 16'hF0F0, 16'h0380);       // R5 false
        step(1, 3, 16'h0000, 16'h0000);       // R10 vacuous set
        step(1, 4, 16'hFFFF, 16'h0000);       // R10 vacuous clear
        step(1, 0, 16'h5A5A, 16'h0000);       // R10 modify no-op
        step(1, 1, 16'h5A5A, 16'h0000);
        step(1, 2, 16'h5A5A, 16'h0000);
        step(1, 3, 16'hFFFF, 16'hFFFF);       // full mask
        step(1, 4, 16'h0001, 16'hFFFF);
        step(1, 6, 16'h0F00, 16'h00F0);       // R6
        step(1, 7, 16'hFFFF, 16'h0F0F);
        step(1, 8, 16'h00FF, 16'h1234);       // R6 NOT ignores mask
        step(1, 8, 16'h00FF, 16'hFFFF);
        step(1, 9, 16'hBEEF, 16'h1111);       // R11
        step(1, 15, 16'hCAFE, 16'hFFFF);      // R11
        step(0, 2, 16'hFFFF, 16'hFFFF);       // R9 idle holds
        step(0, 3, 16'h0000, 16'h0000);
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom_range(0, 3) != 0), 4'($urandom_range(0, 15)),
                 16'($urandom), (i % 7 == 0) ? 16'h0 : 16'($urandom));
        end
        step(0, 0, 16'h0, 16'h0);
        step(0, 0, 16'h0, 16'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule